// File: doc/BRIEF.md
# Double-Buffered PWM Comparison Unit

This block compares a free-running PWM period counter with a programmable 16-bit comparison value. It emits a one-cycle match pulse when the two agree and comparison is enabled. Software never writes the live comparison settings directly. It writes a value shadow and a configuration shadow. The configuration holds a compare enable and a 4-bit update window length. The live registers take the shadow contents only at a synchronisation instant. Because of this, settings can change while the channel keeps running, and no half-updated setting can produce a stray match.

The synchronisation instant is a period-end strobe that arrives while a 4-bit window counter equals the live window length. The window counter advances at every period end and wraps to zero at that instant. A configuration-shadow write arms the transfer, and the arm flag clears when the transfer happens. A value-shadow write on its own arms nothing. It only takes effect once a configuration write follows it.

Top module: `dbl_pwm_compare`

## Requirements
- R1: After reset, the live value, live enable, live window length, window counter, pending flag and match pulse are all zero.
- R2: A value-shadow write with no later configuration-shadow write leaves the live value unchanged across any number of period ends, and it does not set the pending flag.
- R3: A configuration-shadow write sets the pending flag in the next cycle. A transfer clears the flag, unless a configuration write lands in the same cycle as the transfer.
- R4: A transfer happens when a period end arrives, the window counter equals the live window length, and the pending flag is set. It copies both shadows (value; enable bit and window length) into the live registers.
- R5: Each period end increments the window counter, except when the counter equals the live window length; then the counter returns to zero. The counter never exceeds the live window length.
- R6: When a shadow is written several times between transfers, only the last written contents become live.
- R7: When a shadow write coincides with a transfer, the transfer copies the previously held shadow contents. A coinciding configuration write stays pending for the next instant.
- R8: When compare is enabled and the counter equals the live value, the match output goes high in the following cycle for exactly one cycle, even if the equality is held.
- R9: When the live enable bit is 0, the match output stays low.
- R10: The live registers change only in a cycle in which a transfer occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| valWrEn | input | 1 | Value-shadow write strobe |
| valWrData | input | 16 | Data for the value shadow |
| cfgWrEn | input | 1 | Configuration-shadow write strobe; arms a transfer |
| cfgWrEnable | input | 1 | Compare enable bit for the configuration shadow |
| cfgWrPeriod | input | 4 | Window length for the configuration shadow |
| periodCnt | input | 16 | Running PWM period counter |
| periodEnd | input | 1 | One-cycle strobe marking the end of a PWM period |
| matchPulse | output | 1 | One-cycle comparison match pulse |
| activeValue | output | 16 | Live comparison value |
| activeEnable | output | 1 | Live compare enable |
| activeUpdPeriod | output | 4 | Live window length |
| updCount | output | 4 | Window counter |
| xferPending | output | 1 | Transfer armed and waiting |

## Verification
The bench writes a value shadow with no configuration write after it. A design that armed on value writes would show the new value live after the next period end. It then opens a three-period window and checks that the live value stays put for the first two period ends. Transferring on every period end would expose the new value too early. A collision case puts shadow writes and a transfer instant in one cycle. A design that forwarded the new write would show it at once, and one that dropped the pending flag would never show it. A held counter equality must give one pulse, not a level, and a disabled compare must give none.

// File: rtl/pwmcmp_pkg.sv
package pwmcmp_pkg;
  localparam int VAL_W = 16;
  localparam int PER_W = 4;

  typedef struct packed {
    logic             en;
    logic [PER_W-1:0] per;
  } cmpCfg_t;

  typedef struct packed {
    logic shValWr;
    logic shCfgWr;
    logic xfer;
  } ctrlStb_t;
endpackage

// File: rtl/pwmcmp_ctrl.sv
module pwmcmp_ctrl
  import pwmcmp_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             valWrEn,
  input  logic             cfgWrEn,
  input  logic             periodEnd,
  input  logic [PER_W-1:0] actPer,
  output ctrlStb_t         stb,
  output logic [PER_W-1:0] updCount,
  output logic             pending
);
  logic instant;

  assign instant     = periodEnd && (updCount == actPer);
  assign stb.shValWr = valWrEn;
  assign stb.shCfgWr = cfgWrEn;
  assign stb.xfer    = instant && pending;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pending  <= 1'b0;
      updCount <= '0;
    end else begin
      if (cfgWrEn)       pending <= 1'b1;
      else if (stb.xfer) pending <= 1'b0;
      if (periodEnd) begin
        if (instant) updCount <= '0;
        else         updCount <= updCount + 1'b1;
      end
    end
  end

  // R3
  pend_set_chk: assert property (@(posedge clk) disable iff (!rstN)
    cfgWrEn |=> pending);

  // R3
  pend_clr_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stb.xfer && !cfgWrEn) |=> !pending);

  // R5
  upd_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    updCount <= actPer);

  // R5
  upd_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !periodEnd |=> $stable(updCount));
endmodule

// File: rtl/pwmcmp_dpath.sv
module pwmcmp_dpath
  import pwmcmp_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  ctrlStb_t         stb,
  input  logic [VAL_W-1:0] valWrData,
  input  cmpCfg_t          cfgWrData,
  input  logic [VAL_W-1:0] periodCnt,
  output logic [VAL_W-1:0] actVal,
  output cmpCfg_t          actCfg,
  output logic             matchPulse
);
  logic [VAL_W-1:0] shVal;
  cmpCfg_t          shCfg;
  logic             hit;
  logic             hitPrev;

  assign hit = actCfg.en && (periodCnt == actVal);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      shVal      <= '0;
      shCfg      <= '0;
      actVal     <= '0;
      actCfg     <= '0;
      hitPrev    <= 1'b0;
      matchPulse <= 1'b0;
    end else begin
      if (stb.shValWr) shVal <= valWrData;
      if (stb.shCfgWr) shCfg <= cfgWrData;
      if (stb.xfer) begin
        actVal <= shVal;
        actCfg <= shCfg;
      end
      hitPrev    <= hit;
      matchPulse <= hit && !hitPrev;
    end
  end

  // R10
  act_stable_chk: assert property (@(posedge clk) disable iff (!rstN)
    !stb.xfer |=> ($stable(actVal) && $stable(actCfg)));

  // R8
  pulse_width_chk: assert property (@(posedge clk) disable iff (!rstN)
    matchPulse |=> !matchPulse);

  // R9
  pulse_en_chk: assert property (@(posedge clk) disable iff (!rstN)
    matchPulse |-> $past(actCfg.en));

  // R8
  pulse_val_chk: assert property (@(posedge clk) disable iff (!rstN)
    matchPulse |-> ($past(periodCnt) == $past(actVal)));
endmodule

// File: rtl/dbl_pwm_compare.sv
module dbl_pwm_compare
  import pwmcmp_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             valWrEn,
  input  logic [VAL_W-1:0] valWrData,
  input  logic             cfgWrEn,
  input  logic             cfgWrEnable,
  input  logic [PER_W-1:0] cfgWrPeriod,
  input  logic [VAL_W-1:0] periodCnt,
  input  logic             periodEnd,
  output logic             matchPulse,
  output logic [VAL_W-1:0] activeValue,
  output logic             activeEnable,
  output logic [PER_W-1:0] activeUpdPeriod,
  output logic [PER_W-1:0] updCount,
  output logic             xferPending
);
  ctrlStb_t stb;
  cmpCfg_t  cfgIn;
  cmpCfg_t  actCfg;

  assign cfgIn.en        = cfgWrEnable;
  assign cfgIn.per       = cfgWrPeriod;
  assign activeEnable    = actCfg.en;
  assign activeUpdPeriod = actCfg.per;

  pwmcmp_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .valWrEn  (valWrEn),
    .cfgWrEn  (cfgWrEn),
    .periodEnd(periodEnd),
    .actPer   (actCfg.per),
    .stb      (stb),
    .updCount (updCount),
    .pending  (xferPending)
  );

  pwmcmp_dpath u_dpath (
    .clk       (clk),
    .rstN      (rstN),
    .stb       (stb),
    .valWrData (valWrData),
    .cfgWrData (cfgIn),
    .periodCnt (periodCnt),
    .actVal    (activeValue),
    .actCfg    (actCfg),
    .matchPulse(matchPulse)
  );
endmodule

// File: tb/test_dbl_pwm_compare.sv
module test_dbl_pwm_compare;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        valWrEn = 1'b0;
  logic [15:0] valWrData = '0;
  logic        cfgWrEn = 1'b0;
  logic        cfgWrEnable = 1'b0;
  logic [3:0]  cfgWrPeriod = '0;
  logic [15:0] periodCnt = '0;
  logic        periodEnd = 1'b0;
  logic        matchPulse;
  logic [15:0] activeValue;
  logic        activeEnable;
  logic [3:0]  activeUpdPeriod;
  logic [3:0]  updCount;
  logic        xferPending;

  int total = 0;
  int bad = 0;
  int cycles = 0;

  always #2.5 clk = ~clk;

  dbl_pwm_compare i_dbl_pwm_compare (
    .clk(clk), .rstN(rstN), .valWrEn(valWrEn), .valWrData(valWrData),
    .cfgWrEn(cfgWrEn), .cfgWrEnable(cfgWrEnable), .cfgWrPeriod(cfgWrPeriod),
    .periodCnt(periodCnt), .periodEnd(periodEnd), .matchPulse(matchPulse),
    .activeValue(activeValue), .activeEnable(activeEnable),
    .activeUpdPeriod(activeUpdPeriod), .updCount(updCount),
    .xferPending(xferPending)
  );

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wrVal(input logic [15:0] v);
    @(negedge clk); valWrEn = 1'b1; valWrData = v;
    @(negedge clk); valWrEn = 1'b0;
  endtask

  task automatic wrCfg(input logic en, input logic [3:0] per);
    @(negedge clk); cfgWrEn = 1'b1; cfgWrEnable = en; cfgWrPeriod = per;
    @(negedge clk); cfgWrEn = 1'b0;
  endtask

  task automatic endPeriod();
    @(negedge clk); periodEnd = 1'b1;
    @(negedge clk); periodEnd = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1 value", activeValue, 0);
    chk("R1 enable", activeEnable, 0);
    chk("R1 period", activeUpdPeriod, 0);
    chk("R1 count", updCount, 0);
    chk("R1 pending", xferPending, 0);
    chk("R1 match", matchPulse, 0);
  endtask

  task automatic t_valOnly();
    wrVal(16'h1234);
    chk("R2 pending", xferPending, 0);
    endPeriod();
    endPeriod();
    chk("R2 value", activeValue, 0);
    chk("R2 enable", activeEnable, 0);
  endtask

  task automatic t_cfgXfer();
    wrCfg(1'b1, 4'd0);
    chk("R3 set", xferPending, 1);
    chk("R10 before", activeValue, 0);
    endPeriod();
    chk("R4 value", activeValue, 16'h1234);
    chk("R4 enable", activeEnable, 1);
    chk("R3 clear", xferPending, 0);
  endtask

  task automatic t_window();
    wrCfg(1'b1, 4'd2);
    endPeriod();
    chk("R4 period", activeUpdPeriod, 2);
    chk("R5 wrap", updCount, 0);
    wrVal(16'h00AA);
    wrCfg(1'b1, 4'd2);
    endPeriod();
    chk("R5 inc1", updCount, 1);
    chk("R10 hold1", activeValue, 16'h1234);
    endPeriod();
    chk("R5 inc2", updCount, 2);
    chk("R10 hold2", activeValue, 16'h1234);
    endPeriod();
    chk("R4 window xfer", activeValue, 16'h00AA);
    chk("R5 wrap2", updCount, 0);
  endtask

  task automatic t_lastWins();
    wrVal(16'h0005);
    wrVal(16'h0007);
    wrCfg(1'b1, 4'd1);
    wrCfg(1'b1, 4'd0);
    endPeriod();
    endPeriod();
    endPeriod();
    chk("R6 value", activeValue, 16'h0007);
    chk("R6 period", activeUpdPeriod, 0);
  endtask

  task automatic t_collision();
    wrVal(16'h0111);
    wrCfg(1'b1, 4'd0);
    @(negedge clk);
    valWrEn = 1'b1; valWrData = 16'h0222;
    cfgWrEn = 1'b1; cfgWrEnable = 1'b1; cfgWrPeriod = 4'd0;
    periodEnd = 1'b1;
    @(negedge clk);
    valWrEn = 1'b0; cfgWrEn = 1'b0; periodEnd = 1'b0;
    chk("R7 old value", activeValue, 16'h0111);
    chk("R7 still pending", xferPending, 1);
    endPeriod();
    chk("R7 next value", activeValue, 16'h0222);
    chk("R7 cleared", xferPending, 0);
  endtask

  task automatic t_match();
    @(negedge clk); periodCnt = 16'h0221;
    @(negedge clk);
    chk("R8 no early", matchPulse, 0);
    periodCnt = 16'h0222;
    @(negedge clk);
    chk("R8 pulse", matchPulse, 1);
    @(negedge clk);
    chk("R8 single", matchPulse, 0);
    periodCnt = 16'h0223;
    @(negedge clk);
    chk("R8 after", matchPulse, 0);
  endtask

  task automatic t_disabled();
    wrCfg(1'b0, 4'd0);
    endPeriod();
    chk("R9 enable off", activeEnable, 0);
    @(negedge clk); periodCnt = 16'h0222;
    @(negedge clk);
    chk("R9 no pulse1", matchPulse, 0);
    @(negedge clk);
    chk("R9 no pulse2", matchPulse, 0);
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 100000) begin
        total++;
        bad++;
        $display("FAIL watchdog: actual=%0d expected=done", cycles);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    t_reset();
    t_valOnly();
    t_cfgXfer();
    t_window();
    t_lastWins();
    t_collision();
    t_match();
    t_disabled();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule